// File: doc/BRIEF.md
# SPI Target with Byte-Complete Flag

This block is an 8-bit serial peripheral interface target with clock polarity fixed at idle-low. An external controller drives the serial clock, the controller-to-target data line and an active-low select. The block returns data on its own output line, most significant bit first. The block runs on its own system clock. The three bus inputs pass through a synchronizer, and every bus edge is detected as a one-cycle event. The sampling edge and the launching edge both follow a phase setting held in a control register.

Software uses a small register port. It loads the next outgoing byte into a pending buffer and reads the last received byte from a holding register. It sets the phase, and it polls a status bit that rises when a byte completes. The pending buffer is separate from the shift register, and the shift register takes a new value only at a byte boundary. Because of this, the next byte can be written at any time, including the short window just after the completion flag rises. Bit alignment of the following byte is not affected.

Top module: `spi_target_core`

## Requirements
- R1: After reset, status bit 0 reads 0, the data register reads 0x00, the control register reads 0x00 and the serial output is low.
- R2: With phase 0 (control bit 0 = 0), the MSB of the loaded byte appears on the serial output once select is active and before the first clock edge. Later bits change after falling edges, and input bits are captured on rising edges.
- R3: With phase 1 (control bit 0 = 1), the serial output changes after each rising (leading) edge, and input bits are captured on falling (trailing) edges, MSB first.
- R4: Status register (address 2) bit 0 sets on the eighth sampling edge of a byte: a rising edge in phase 0, a falling edge in phase 1.
- R5: The data register (address 0) read value is the received byte. It is updated only when the completion flag sets and is stable at all other times.
- R6: A write to address 0 only fills the pending buffer and does not change the byte being shifted out. The shift register copies the pending buffer only at a byte start: select going active (phase 0), the first launch edge after a completed byte, or the first rising edge of a byte in phase 1.
- R7: In phase 0, a write to address 0 made after the flag sets but before the next falling edge is sent complete and aligned as the next byte within the same select period.
- R8: Raising select part-way through a byte discards the partial bits. That partial byte does not set the flag, and the next full byte is received and sent correctly.
- R9: The flag clears only when a read of the status register finds it set and is followed by a read of the data register. A data read without that preceding status read leaves the flag set. A new completion in the same cycle as the clearing read wins.
- R10: The serial output is held low while select is inactive.
- R11: Control register (address 1) bit 0 holds the phase and reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock from the controller, idle low |
| mosi_i | input | 1 | Serial data from the controller |
| ss_n_i | input | 1 | Active-low target select |
| miso_o | output | 1 | Serial data to the controller |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (clear sequence side effects) |
| reg_addr_i | input | 2 | Register address: 0 data, 1 control, 2 status |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data, combinational on address |

## Verification
The bench first reproduces the late-load hazard. Inside one select period in phase 0, it reads the status and the received byte and then writes the next byte, all between the last rising edge and the next falling edge. A design that copies a write straight into the shift register, or that restarts its bit count on a write, returns the second byte shifted by one place. The bench also writes a new byte just after select asserts to confirm that the byte being sent is left alone. It aborts a byte after three bits to catch a bit counter that is not cleared, which would misalign the next byte or raise a false completion. Finally it checks the two-step flag clear, where a design that clears on a lone data read would lose completions.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;

  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_CTRL = 2'd1,
    REG_STAT = 2'd2
  } reg_sel_e;

  typedef struct packed {
    logic sel;
    logic sel_start;
    logic sel_end;
    logic sck_rise;
    logic sck_fall;
    logic mosi;
  } bus_evt_t;

endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync
  import spi_tgt_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sck_i,
  input  logic     mosi_i,
  input  logic     ss_n_i,
  output bus_evt_t evt
);

  localparam int NSIG = 3;
  localparam int IDX_SEL = 0;
  localparam int IDX_MOSI = 1;
  localparam int IDX_SCK = 2;

  logic [NSIG-1:0] raw;
  logic [STAGES-1:0][NSIG-1:0] stg;
  logic [NSIG-1:0] cur;
  logic [NSIG-1:0] last;

  assign raw = {sck_i, mosi_i, ~ss_n_i};
  assign cur = stg[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg  <= '0;
      last <= '0;
    end else begin
      stg[0] <= raw;
      for (int i = 1; i < STAGES; i++) begin
        stg[i] <= stg[i-1];
      end
      last <= cur;
    end
  end

  always_comb begin
    evt.sel       = cur[IDX_SEL];
    evt.sel_start = cur[IDX_SEL] & ~last[IDX_SEL];
    evt.sel_end   = ~cur[IDX_SEL] & last[IDX_SEL];
    evt.sck_rise  = cur[IDX_SCK] & ~last[IDX_SCK];
    evt.sck_fall  = ~cur[IDX_SCK] & last[IDX_SCK];
    evt.mosi      = cur[IDX_MOSI];
  end

endmodule

// File: rtl/spi_tgt_engine.sv
module spi_tgt_engine
  import spi_tgt_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_evt_t          evt,
  input  logic              cpha,
  input  logic [DATA_W-1:0] pend_data,
  output logic              miso,
  output logic              byte_done,
  output logic [DATA_W-1:0] rx_byte,
  output logic              sample_evt,
  output logic              launch_evt,
  output logic              load_evt,
  output logic [CNT_W-1:0]  bit_cnt
);

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  function automatic logic [DATA_W-1:0] shift_in(input logic [DATA_W-1:0] v, input logic b);
    return {v[DATA_W-2:0], b};
  endfunction

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c);
    return (c == LAST_BIT) ? '0 : c + 1'b1;
  endfunction

  logic [DATA_W-1:0] rx_shift;
  logic [DATA_W-1:0] tx_shift;
  logic              at_boundary;
  logic              shift_evt;

  assign sample_evt  = evt.sel & (cpha ? evt.sck_fall : evt.sck_rise);
  assign launch_evt  = evt.sel & (cpha ? evt.sck_rise : evt.sck_fall);
  assign at_boundary = (bit_cnt == '0);
  assign load_evt    = (evt.sel_start & ~cpha) | (launch_evt & at_boundary);
  assign shift_evt   = launch_evt & ~at_boundary;
  assign byte_done   = sample_evt & (bit_cnt == LAST_BIT);
  assign miso        = evt.sel & tx_shift[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
    end else if (evt.sel_start || evt.sel_end) begin
      bit_cnt <= '0;
    end else if (sample_evt) begin
      bit_cnt <= next_count(bit_cnt);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_shift <= '0;
      rx_byte  <= '0;
    end else if (sample_evt) begin
      rx_shift <= shift_in(rx_shift, evt.mosi);
      if (byte_done) begin
        rx_byte <= shift_in(rx_shift, evt.mosi);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_shift <= '0;
    end else if (load_evt) begin
      tx_shift <= pend_data;
    end else if (shift_evt) begin
      tx_shift <= shift_in(tx_shift, 1'b0);
    end
  end

endmodule

// File: rtl/spi_tgt_regs.sv
module spi_tgt_regs
  import spi_tgt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              byte_done,
  input  logic [DATA_W-1:0] rx_byte,
  output logic              cpha,
  output logic [DATA_W-1:0] pend_data,
  output logic              done_flag,
  output logic              clear_evt
);

  logic arm;
  logic sel_data;
  logic sel_ctrl;
  logic sel_stat;

  assign sel_data  = (reg_addr == REG_DATA);
  assign sel_ctrl  = (reg_addr == REG_CTRL);
  assign sel_stat  = (reg_addr == REG_STAT);
  assign clear_evt = reg_rd & sel_data & arm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_data <= '0;
      cpha      <= 1'b0;
    end else if (reg_wr) begin
      if (sel_data) pend_data <= reg_wdata;
      if (sel_ctrl) cpha      <= reg_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_flag <= 1'b0;
      arm       <= 1'b0;
    end else begin
      if (byte_done)      done_flag <= 1'b1;
      else if (clear_evt) done_flag <= 1'b0;
      if (clear_evt)                           arm <= 1'b0;
      else if (reg_rd && sel_stat && done_flag) arm <= 1'b1;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (sel_data)      reg_rdata = rx_byte;
    else if (sel_ctrl) reg_rdata[0] = cpha;
    else if (sel_stat) reg_rdata[0] = done_flag;
  end

endmodule

// File: rtl/spi_target_core.sv
module spi_target_core
  import spi_tgt_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_i,
  input  logic              mosi_i,
  input  logic              ss_n_i,
  output logic              miso_o,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o
);

  localparam int CNT_W = $clog2(DATA_W);

  bus_evt_t          bus_evt;
  logic              cpha;
  logic [DATA_W-1:0] pend_data;
  logic [DATA_W-1:0] rx_byte;
  logic              byte_done;
  logic              done_flag;
  logic              clear_evt;
  logic              sample_evt;
  logic              launch_evt;
  logic              load_evt;
  logic [CNT_W-1:0]  bit_cnt;
  logic              sel_act;
  logic              sel_end;

  assign sel_act = bus_evt.sel;
  assign sel_end = bus_evt.sel_end;

  spi_tgt_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .sck_i  (sck_i),
    .mosi_i (mosi_i),
    .ss_n_i (ss_n_i),
    .evt    (bus_evt)
  );

  spi_tgt_engine #(.DATA_W(DATA_W), .CNT_W(CNT_W)) engine_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt        (bus_evt),
    .cpha       (cpha),
    .pend_data  (pend_data),
    .miso       (miso_o),
    .byte_done  (byte_done),
    .rx_byte    (rx_byte),
    .sample_evt (sample_evt),
    .launch_evt (launch_evt),
    .load_evt   (load_evt),
    .bit_cnt    (bit_cnt)
  );

  spi_tgt_regs #(.DATA_W(DATA_W)) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr_i),
    .reg_rd    (reg_rd_i),
    .reg_addr  (reg_addr_i),
    .reg_wdata (reg_wdata_i),
    .reg_rdata (reg_rdata_o),
    .byte_done (byte_done),
    .rx_byte   (rx_byte),
    .cpha      (cpha),
    .pend_data (pend_data),
    .done_flag (done_flag),
    .clear_evt (clear_evt)
  );

endmodule

// File: rtl/spi_target_core_chk.sv
module spi_target_core_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_act,
  input logic              sel_end,
  input logic              load_evt,
  input logic              byte_done,
  input logic              clear_evt,
  input logic              done_flag,
  input logic              miso_o,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic [DATA_W-1:0] rx_byte
);

  AST_DONE_FOLLOWS_LAST_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> done_flag); // R4

  AST_RX_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_done |=> $stable(rx_byte)); // R5

  AST_LOAD_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |-> (bit_cnt == '0)); // R6

  AST_DESELECT_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    sel_end |=> (bit_cnt == '0)); // R8

  AST_CLEAR_DROPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_evt && !byte_done) |=> !done_flag); // R9

  AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_act |-> !miso_o); // R10

endmodule

bind spi_target_core spi_target_core_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .sel_act   (sel_act),
  .sel_end   (sel_end),
  .load_evt  (load_evt),
  .byte_done (byte_done),
  .clear_evt (clear_evt),
  .done_flag (done_flag),
  .miso_o    (miso_o),
  .bit_cnt   (bit_cnt),
  .rx_byte   (rx_byte)
);

// File: tb/spi_target_core_tb.sv
module spi_target_core_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;
  localparam int NVEC = 6;
  // {phase, byte loaded for sending, byte driven by the controller}
  localparam logic [16:0] VECS [NVEC] = '{
    {1'b0, 8'hA5, 8'h3C},
    {1'b1, 8'hA5, 8'h3C},
    {1'b0, 8'h01, 8'h80},
    {1'b1, 8'h80, 8'h01},
    {1'b0, 8'hFF, 8'h00},
    {1'b1, 8'h6D, 8'hB2}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sck = 1'b0;
  logic       mosi = 1'b0;
  logic       ss_n = 1'b1;
  logic       miso;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_target_core #(.DATA_W(8), .SYNC_STAGES(2)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .sck_i       (sck),
    .mosi_i      (mosi),
    .ss_n_i      (ss_n),
    .miso_o      (miso),
    .reg_wr_i    (reg_wr),
    .reg_rd_i    (reg_rd),
    .reg_addr_i  (reg_addr),
    .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic ss_on();
    ss_n = 1'b0;
    tick(HALF);
  endtask

  task automatic ss_off();
    tick(HALF);
    ss_n = 1'b1;
    tick(2*HALF);
  endtask

  // Controller side: shifts nbits MSB first; optional load inside the gap
  // after the last rising edge (phase 0 only).
  task automatic spi_bits(input logic ph, input logic [7:0] mo, input int nbits,
                          input logic gapw, input logic [7:0] gapv,
                          input logic [7:0] gap_rx, output logic [7:0] mi);
    logic [7:0] d;
    mi = 8'h00;
    for (int k = 0; k < nbits; k++) begin
      if (!ph) begin
        mosi = mo[7-k];
        tick(HALF);
        mi[7-k] = miso;
        sck = 1'b1;
        if (gapw && k == nbits-1) begin
          tick(4);
          reg_read(2'd2, d);
          check("R7 flag set in gap", {31'd0, d[0]}, 32'd1);
          reg_read(2'd0, d);
          check("R7 rx in gap", {24'd0, d}, {24'd0, gap_rx});
          reg_write(2'd0, gapv);
          tick(HALF-7);
        end else begin
          tick(HALF);
        end
        sck = 1'b0;
      end else begin
        sck = 1'b1;
        mosi = mo[7-k];
        tick(HALF);
        mi[7-k] = miso;
        sck = 1'b0;
        tick(HALF);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [7:0] mi;
    logic [7:0] mi2;
    tick(4);
    rst_n = 1'b1;
    tick(1);

    // R1: reset state
    reg_read(2'd2, d); check("R1 status", {24'd0, d}, 32'd0);
    reg_read(2'd0, d); check("R1 data", {24'd0, d}, 32'd0);
    reg_read(2'd1, d); check("R1 ctrl", {24'd0, d}, 32'd0);
    check("R1 miso", {31'd0, miso}, 32'd0);

    // R11: phase bit readback
    reg_write(2'd1, 8'h01);
    reg_read(2'd1, d); check("R11 ctrl readback", {24'd0, d}, 32'd1);

    // Table walk: R2/R3 sending, R4 flag, R5 receive, R9 clear sequence
    for (int v = 0; v < NVEC; v++) begin
      reg_write(2'd1, {7'd0, VECS[v][16]});
      reg_write(2'd0, VECS[v][15:8]);
      ss_on();
      spi_bits(VECS[v][16], VECS[v][7:0], 8, 1'b0, 8'h00, 8'h00, mi);
      ss_off();
      check(VECS[v][16] ? "R3 sent byte" : "R2 sent byte", {24'd0, mi}, {24'd0, VECS[v][15:8]});
      reg_read(2'd2, d); check("R4 flag set", {31'd0, d[0]}, 32'd1);
      reg_read(2'd0, d); check("R5 rx byte", {24'd0, d}, {24'd0, VECS[v][7:0]});
      reg_read(2'd2, d); check("R9 flag cleared", {31'd0, d[0]}, 32'd0);
    end

    // R6: write during a byte only touches the pending buffer
    reg_write(2'd1, 8'h00);
    reg_write(2'd0, 8'h81);
    ss_on();
    check("R2 MSB before first edge", {31'd0, miso}, 32'd1);
    reg_write(2'd0, 8'h7E);
    spi_bits(1'b0, 8'h00, 8, 1'b0, 8'h00, 8'h00, mi);
    spi_bits(1'b0, 8'hFF, 8, 1'b0, 8'h00, 8'h00, mi2);
    ss_off();
    check("R6 current byte kept", {24'd0, mi}, 32'h81);
    check("R6 pending used next", {24'd0, mi2}, 32'h7E);

    // R9: lone data read leaves flag set; status then data clears it
    reg_read(2'd0, d);
    reg_read(2'd2, d); check("R9 lone data read keeps flag", {31'd0, d[0]}, 32'd1);
    reg_read(2'd0, d);
    reg_read(2'd2, d); check("R9 two-step clear", {31'd0, d[0]}, 32'd0);

    // R7: load inside the half-period after the flag, back-to-back bytes
    reg_write(2'd0, 8'h5A);
    ss_on();
    spi_bits(1'b0, 8'h11, 8, 1'b1, 8'hC3, 8'h11, mi);
    spi_bits(1'b0, 8'h22, 8, 1'b0, 8'h00, 8'h00, mi2);
    ss_off();
    check("R7 first byte", {24'd0, mi}, 32'h5A);
    check("R7 late-loaded byte aligned", {24'd0, mi2}, 32'hC3);
    reg_read(2'd2, d);
    reg_read(2'd0, d); check("R7 second rx", {24'd0, d}, 32'h22);

    // R8: abort after three bits
    reg_write(2'd0, 8'h96);
    ss_on();
    spi_bits(1'b0, 8'hE0, 3, 1'b0, 8'h00, 8'h00, mi);
    ss_off();
    reg_read(2'd2, d); check("R8 no flag on partial", {31'd0, d[0]}, 32'd0);
    ss_on();
    spi_bits(1'b0, 8'h69, 8, 1'b0, 8'h00, 8'h00, mi);
    ss_off();
    check("R8 next byte sent", {24'd0, mi}, 32'h96);
    reg_read(2'd2, d);
    reg_read(2'd0, d); check("R8 next byte received", {24'd0, d}, 32'h69);

    // R10: output low when deselected, even with ones loaded
    reg_write(2'd0, 8'hFF);
    ss_on();
    spi_bits(1'b1, 8'h00, 8, 1'b0, 8'h00, 8'h00, mi);
    ss_off();
    check("R10 miso low when idle", {31'd0, miso}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule